// File: doc/BRIEF.md
# Register-Mapped Variable-Length Serial Transfer Master

This block is a serial peripheral interface master. Software sees it as eight 16-bit registers on a simple synchronous bus. To run a transfer, software first loads a 32-bit transmit word as two halfwords. It then writes one command word that sets three things: the length of the transfer (1 to 32 bits), the target device and the mode. The mode is either send only, or send and capture.

The block then does the following:
- It drives the chip select of the addressed device low.
- It shifts the top bits of the transmit word out on MOSI, most significant bit first.
- It samples MISO on each rising serial clock edge and assembles the received bits right-aligned.
- When the transfer ends, it raises completion flags. The flags drive interrupt outputs that software can mask.

Software either polls the status register, which clears the flags when it is read, or waits for an interrupt.

Top module: `serial_xfer_master`

## Requirements
- R1: The registers sit at word addresses 0 to 7 in this order: config A, config B, command, status, tx low, tx high, rx low, rx high. Config A is 16 bits wide and reads back as written. In config A, bit 0 enables the serial clock, bit 4 masks the write-end interrupt and bit 5 masks the read-end interrupt. Config B holds the divider value in bits [3:0] and reads back with the upper bits zero. The tx registers read back as written.
- R2: A command write with bit 0 set starts a send-and-capture transfer. A command write with only bit 1 set starts a send-only transfer. If both bits are set, the transfer is send-and-capture. Bits [6:2] hold the length minus one and bits [9:7] hold the device address. Reading the command register returns these two fields at the same bit positions, with all other bits zero.
- R3: MOSI carries the top N bits of {tx high, tx low}, bit 31 first.
- R4: After a send-and-capture transfer of N bits, {rx high, rx low} holds the received bits in its low N bits, with the last bit received in bit 0 and the bits above N cleared. A send-only transfer leaves the rx registers unchanged.
- R5: The serial clock idles low and follows mode 0 timing: MOSI changes on the falling edge and MISO is sampled on the rising edge. Each half period lasts divider+1 system clocks.
- R6: During a transfer, only the chip select of the addressed device is low. It goes low one half period before the first rising edge and returns high one half period after the last falling edge. Device addresses at or above the number of chip selects assert none.
- R7: Status bit 0 (read end) is set when a send-and-capture transfer completes. Status bit 1 (write end) is set when any transfer completes. Reading the status register clears both bits, and so does starting a transfer.
- R8: The write-end interrupt equals status bit 1 gated by config A bit 4 being 0. The read-end interrupt equals status bit 0 gated by config A bit 5 being 0.
- R9: A command write while a transfer is in progress is ignored. The running transfer keeps its length and device, and the command readback does not change.
- R10: While config A bit 0 is 0, the transfer does not advance. It resumes when the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Register word address |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (a read of status clears the flags) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Active-low chip selects, one per device |
| irqWrEnd | output | 1 | Write-end interrupt request |
| irqRdEnd | output | 1 | Read-end interrupt request |

## Verification
The bench targets these corner cases:
- The two length extremes. A 1-bit transfer catches an off-by-one in the bit counter, which would show up as an extra or missing clock pulse. A full 32-bit transfer catches a truncated shift register.
- Received data that must land right-aligned with stale upper bits cleared. A design that skips the clear leaves bits from an earlier longer transfer in rx high.
- The ordering of chip-select edges against the clock edges, and the clock period itself. A wrong divider or a missing lead or trail half period shifts the measured times.
- A command written mid-transfer, a device address with no chip select, clock-enable stalls, masking, and clear-on-read. Getting any of these wrong produces a visibly wrong pulse count, chip-select pattern or flag value.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 5;
  localparam int DEV_W  = 3;

  localparam logic [2:0] ADDR_CFGA = 3'd0;
  localparam logic [2:0] ADDR_CFGB = 3'd1;
  localparam logic [2:0] ADDR_CMD  = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_TXLO = 3'd4;
  localparam logic [2:0] ADDR_TXHI = 3'd5;
  localparam logic [2:0] ADDR_RXLO = 3'd6;
  localparam logic [2:0] ADDR_RXHI = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // copy tx word into the shifter, clear receive shifter
    logic shift;   // advance transmit shifter (falling edge)
    logic sample;  // capture miso (rising edge)
    logic commit;  // copy receive shifter into rx registers
  } sxmStrobe_t;
endpackage

// File: rtl/sxm_ctrl.sv
module sxm_ctrl
  import sxm_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [15:0]       busWdata,
  output sxmStrobe_t        stb,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output logic              irqWrEnd,
  output logic              irqRdEnd,
  output logic [15:0]       cfgAView,
  output logic [15:0]       cfgBView,
  output logic [15:0]       cmdView,
  output logic [15:0]       statView,
  output logic              busy,
  output logic              clkEn,
  output logic              weFlag,
  output logic              reFlag
);
  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} state_t;

  state_t             state;
  logic [15:0]        cfgAReg;
  logic [DIV_W-1:0]   divReg;
  logic [LEN_W-1:0]   lenM1;
  logic [DEV_W-1:0]   devReg;
  logic               rwReg;
  logic [DIV_W-1:0]   halfCnt;
  logic [LEN_W-1:0]   bitCnt;
  logic               sclkR;

  logic cmdWr, startReq, tick, statRd, done, lastBit;

  assign clkEn    = cfgAReg[0];
  assign busy     = (state != S_IDLE);
  assign cmdWr    = busWe && (busAddr == ADDR_CMD);
  assign startReq = cmdWr && (busWdata[0] || busWdata[1]) && !busy;
  assign tick     = clkEn && busy && (halfCnt == divReg);
  assign statRd   = busRe && (busAddr == ADDR_STAT);
  assign done     = tick && (state == S_TRAIL);
  assign lastBit  = (bitCnt == lenM1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cfgAReg <= '0;
      divReg  <= '0;
      lenM1   <= '0;
      devReg  <= '0;
      rwReg   <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclkR   <= 1'b0;
      weFlag  <= 1'b0;
      reFlag  <= 1'b0;
    end else begin
      if (busWe && busAddr == ADDR_CFGA) cfgAReg <= busWdata;
      if (busWe && busAddr == ADDR_CFGB) divReg  <= busWdata[DIV_W-1:0];
      if (cmdWr && !busy) begin
        lenM1  <= busWdata[6:2];
        devReg <= busWdata[9:7];
        rwReg  <= busWdata[0];
      end

      if (!busy || tick) halfCnt <= '0;
      else if (clkEn)    halfCnt <= halfCnt + 1'b1;

      unique case (state)
        S_IDLE: if (startReq) begin
          state  <= S_LEAD;
          bitCnt <= '0;
          sclkR  <= 1'b0;
        end
        S_LEAD: if (tick) begin
          state <= S_SHIFT;
          sclkR <= 1'b1;
        end
        S_SHIFT: if (tick) begin
          if (sclkR) begin
            sclkR <= 1'b0;
            if (lastBit) state  <= S_TRAIL;
            else         bitCnt <= bitCnt + 1'b1;
          end else begin
            sclkR <= 1'b1;
          end
        end
        S_TRAIL: if (tick) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (startReq) begin
        weFlag <= 1'b0;
        reFlag <= 1'b0;
      end else if (done) begin
        weFlag <= 1'b1;
        reFlag <= rwReg;
      end else if (statRd) begin
        weFlag <= 1'b0;
        reFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.load   = startReq;
    stb.sample = tick && ((state == S_LEAD) || (state == S_SHIFT && !sclkR));
    stb.shift  = tick && (state == S_SHIFT) && sclkR && !lastBit;
    stb.commit = done && rwReg;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !(busy && (devReg == DEV_W'(i)));
  end

  assign sclk     = sclkR;
  assign irqWrEnd = weFlag && !cfgAReg[4];
  assign irqRdEnd = reFlag && !cfgAReg[5];
  assign cfgAView = cfgAReg;
  assign cfgBView = {{(16-DIV_W){1'b0}}, divReg};
  assign cmdView  = {6'b0, devReg, lenM1, 2'b00};
  assign statView = {14'b0, weFlag, reFlag};
endmodule

// File: rtl/sxm_dpath.sv
module sxm_dpath
  import sxm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  busAddr,
  input  logic        busWe,
  input  logic [15:0] busWdata,
  input  sxmStrobe_t  stb,
  input  logic        miso,
  output logic        mosi,
  output logic [15:0] txLo,
  output logic [15:0] txHi,
  output logic [15:0] rxLo,
  output logic [15:0] rxHi
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txLo    <= '0;
      txHi    <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (busWe && busAddr == ADDR_TXLO) txLo <= busWdata;
      if (busWe && busAddr == ADDR_TXHI) txHi <= busWdata;
      if (stb.load)       txShift <= {txHi, txLo};
      else if (stb.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (stb.load)        rxShift <= '0;
      else if (stb.sample) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (stb.commit) rxWord <= rxShift;
    end
  end

  assign mosi = txShift[DATA_W-1];
  assign rxLo = rxWord[15:0];
  assign rxHi = rxWord[31:16];
endmodule

// File: rtl/serial_xfer_master.sv
module serial_xfer_master
  import sxm_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN,
  output logic              irqWrEnd,
  output logic              irqRdEnd
);
  sxmStrobe_t  stb;
  logic [15:0] cfgAView, cfgBView, cmdView, statView;
  logic [15:0] txLo, txHi, rxLo, rxHi;
  logic        ctlBusy, ctlClkEn, ctlWe, ctlRe;

  sxm_ctrl #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .stb(stb), .sclk(sclk), .csN(csN),
    .irqWrEnd(irqWrEnd), .irqRdEnd(irqRdEnd), .cfgAView(cfgAView),
    .cfgBView(cfgBView), .cmdView(cmdView), .statView(statView),
    .busy(ctlBusy), .clkEn(ctlClkEn), .weFlag(ctlWe), .reFlag(ctlRe)
  );

  sxm_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .stb(stb), .miso(miso), .mosi(mosi),
    .txLo(txLo), .txHi(txHi), .rxLo(rxLo), .rxHi(rxHi)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CFGA: busRdata = cfgAView;
      ADDR_CFGB: busRdata = cfgBView;
      ADDR_CMD:  busRdata = cmdView;
      ADDR_STAT: busRdata = statView;
      ADDR_TXLO: busRdata = txLo;
      ADDR_TXHI: busRdata = txHi;
      ADDR_RXLO: busRdata = rxLo;
      default:   busRdata = rxHi;
    endcase
  end
endmodule

// File: rtl/sxm_checker.sv
module sxm_checker #(
  parameter int NUM_CS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic [NUM_CS-1:0] csN,
  input logic              busy,
  input logic              clkEn,
  input logic              weFlag,
  input logic              reFlag
);
  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~csN)); // R6

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk); // R5

  AST_STALL_HOLDS_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !clkEn |=> $stable(sclk)); // R10

  AST_FLAG_FROM_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(weFlag) |-> $past(busy)); // R7

  AST_RE_IMPLIES_WE: assert property (@(posedge clk) disable iff (!rst_n)
    reFlag |-> weFlag); // R7

  AST_CS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&csN)); // R6
endmodule

bind serial_xfer_master sxm_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .csN(csN), .busy(ctlBusy),
  .clkEn(ctlClkEn), .weFlag(ctlWe), .reFlag(ctlRe)
);

// File: tb/serial_xfer_master_tb.sv
`timescale 1ns/1ps
module serial_xfer_master_tb;
  localparam int NCS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWe = 1'b0;
  logic busRe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic sclk, mosi;
  logic miso = 1'b0;
  logic [NCS-1:0] csN;
  logic irqWrEnd, irqRdEnd;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  serial_xfer_master #(.NUM_CS(NCS), .DIV_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .irqWrEnd(irqWrEnd), .irqRdEnd(irqRdEnd)
  );

  // slave model and edge monitors
  logic [31:0] slavePat = '0;
  int slaveIdx = 0;
  int riseCnt = 0;
  logic [31:0] mosiCap = '0;
  logic [NCS-1:0] csSeen = '0;
  realtime tRise = 0, tPrevRise = 0, tFirstRise = 0, tLastFall = 0;
  realtime tCsFall = 0, tCsRise = 0;
  wire csLowAny = ~&csN;

  always @(posedge sclk) begin
    riseCnt = riseCnt + 1;
    mosiCap = {mosiCap[30:0], mosi};
    tPrevRise = tRise;
    tRise = $realtime;
    if (riseCnt == 1) tFirstRise = $realtime;
  end
  always @(negedge sclk) begin
    tLastFall = $realtime;
    slaveIdx = slaveIdx + 1;
    if (slaveIdx < 32) miso = slavePat[31 - slaveIdx];
  end
  always @(posedge csLowAny) tCsFall = $realtime;
  always @(negedge csLowAny) tCsRise = $realtime;
  always @(posedge clk) csSeen = csSeen | ~csN;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic armMonitors(input logic [31:0] pat);
    slavePat = pat; slaveIdx = 0; miso = pat[31];
    riseCnt = 0; mosiCap = '0; csSeen = '0;
  endtask

  task automatic runXfer(input int len, input int dev, input logic [1:0] mode,
                         input logic [31:0] tx, input logic [31:0] pat, input int div);
    busWrite(3'd1, 16'(div));
    busWrite(3'd4, tx[15:0]);
    busWrite(3'd5, tx[31:16]);
    armMonitors(pat);
    busWrite(3'd2, 16'(mode) | 16'((len - 1) << 2) | 16'(dev << 7));
    repeat ((2 * len + 4) * (div + 1) + 6) @(negedge clk);
  endtask

  task automatic tReset();
    logic [15:0] d;
    chk("R6 reset csN", 32'(csN), 32'(5'h1f));
    chk("R5 reset sclk", 32'(sclk), 0);
    chk("R8 reset irq", 32'({irqWrEnd, irqRdEnd}), 0);
    busRead(3'd3, d); chk("R7 reset status", 32'(d), 0);
    busRead(3'd1, d); chk("R1 reset cfgB", 32'(d), 0);
  endtask

  task automatic tRegs();
    logic [15:0] d;
    busWrite(3'd0, 16'hA5F1); busRead(3'd0, d); chk("R1 cfgA readback", 32'(d), 32'hA5F1);
    busWrite(3'd1, 16'hFFF3); busRead(3'd1, d); chk("R1 cfgB readback", 32'(d), 32'h0003);
    busWrite(3'd4, 16'h1357); busRead(3'd4, d); chk("R1 txLo readback", 32'(d), 32'h1357);
    busWrite(3'd5, 16'h2468); busRead(3'd5, d); chk("R1 txHi readback", 32'(d), 32'h2468);
    busWrite(3'd0, 16'h0001);
  endtask

  task automatic tRw8();
    logic [15:0] d;
    runXfer(8, 2, 2'b01, 32'hC3A5_0000, 32'h5A00_0000, 0);
    chk("R3 mosi 8 bit", mosiCap, 32'h0000_00C3);
    chk("R5 pulse count 8", riseCnt, 8);
    chk("R6 cs of device 2", 32'(csSeen), 32'h04);
    chk("R8 irqs raised", 32'({irqWrEnd, irqRdEnd}), 32'b11);
    busRead(3'd6, d); chk("R4 rxLo 8 bit", 32'(d), 32'h005A);
    busRead(3'd7, d); chk("R4 rxHi 8 bit", 32'(d), 0);
    busRead(3'd3, d); chk("R7 status rw end", 32'(d), 32'h3);
    busRead(3'd3, d); chk("R7 status cleared by read", 32'(d), 0);
  endtask

  task automatic tRw32();
    logic [15:0] lo, hi;
    runXfer(32, 1, 2'b01, 32'h1234_5678, 32'h89AB_CDEF, 3);
    chk("R3 mosi 32 bit", mosiCap, 32'h1234_5678);
    busRead(3'd6, lo); busRead(3'd7, hi);
    chk("R4 rx 32 bit", {hi, lo}, 32'h89AB_CDEF);
    chk("R5 sclk period", 32'(int'(tRise - tPrevRise)), 64);
    chk("R6 cs lead half period", 32'(int'(tFirstRise - tCsFall)), 32);
    chk("R6 cs trail half period", 32'(int'(tCsRise - tLastFall)), 32);
    busRead(3'd3, lo);
  endtask

  task automatic tLen1();
    logic [15:0] lo, hi;
    runXfer(1, 0, 2'b01, 32'h8000_0000, 32'h8000_0000, 0);
    chk("R5 pulse count 1", riseCnt, 1);
    chk("R3 mosi 1 bit", mosiCap, 32'h1);
    busRead(3'd6, lo); busRead(3'd7, hi);
    chk("R4 rx 1 bit upper cleared", {hi, lo}, 32'h1);
    busRead(3'd3, lo);
  endtask

  task automatic tWo17();
    logic [15:0] d;
    runXfer(17, 4, 2'b10, 32'hFFFF_8000, 32'h0F0F_0F0F, 1);
    chk("R3 mosi 17 bit", mosiCap, 32'h0001_FFFF);
    chk("R6 cs of device 4", 32'(csSeen), 32'h10);
    chk("R8 no read irq on send only", 32'({irqWrEnd, irqRdEnd}), 32'b10);
    busRead(3'd6, d); chk("R4 rx kept on send only", 32'(d), 32'h1);
    busRead(3'd3, d); chk("R7 status send only", 32'(d), 32'h2);
  endtask

  task automatic tBoth();
    logic [15:0] d;
    runXfer(8, 3, 2'b11, 32'h0F00_0000, 32'hF000_0000, 0);
    busRead(3'd3, d); chk("R2 both bits gives rw", 32'(d), 32'h3);
    busRead(3'd6, d); chk("R2 rx updated with both bits", 32'(d), 32'h00F0);
    busRead(3'd2, d); chk("R2 command readback", 32'(d), 32'h019C);
  endtask

  task automatic tNoCs();
    logic [15:0] d;
    runXfer(4, 6, 2'b10, 32'hA000_0000, 32'h0, 0);
    chk("R6 no cs for device 6", 32'(csSeen), 0);
    chk("R5 pulse count no cs", riseCnt, 4);
    busRead(3'd3, d);
  endtask

  task automatic tMask();
    logic [15:0] d;
    busWrite(3'd0, 16'h0031);
    runXfer(8, 0, 2'b01, 32'hFF00_0000, 32'h0, 0);
    chk("R8 both masked", 32'({irqWrEnd, irqRdEnd}), 0);
    busWrite(3'd0, 16'h0021);
    @(negedge clk);
    chk("R8 write end unmasked", 32'({irqWrEnd, irqRdEnd}), 32'b10);
    busWrite(3'd0, 16'h0001);
    // flags left set on purpose for the start-clears check later
  endtask

  task automatic tBusy();
    logic [15:0] d;
    busWrite(3'd1, 16'd1);
    armMonitors(32'h0);
    busWrite(3'd2, 16'h0001 | 16'(15 << 2) | 16'(1 << 7));
    repeat (5) @(negedge clk);
    busWrite(3'd2, 16'h0001 | 16'(2 << 2) | 16'(3 << 7));
    repeat ((2 * 16 + 4) * 2 + 6) @(negedge clk);
    chk("R9 length kept while busy", riseCnt, 16);
    chk("R9 device kept while busy", 32'(csSeen), 32'h02);
    busRead(3'd2, d); chk("R9 command readback unchanged", 32'(d), 32'h00BC);
  endtask

  task automatic tStall();
    logic [15:0] d;
    busWrite(3'd0, 16'h0030);
    armMonitors(32'h0);
    busWrite(3'd2, 16'h0002 | 16'(3 << 2));
    repeat (50) @(negedge clk);
    chk("R10 no clock while disabled", riseCnt, 0);
    chk("R10 cs held during stall", 32'(csN[0]), 0);
    busRead(3'd3, d); chk("R7 start clears flags", 32'(d), 0);
    busWrite(3'd0, 16'h0031);
    repeat ((2 * 4 + 4) * 2 + 6) @(negedge clk);
    chk("R10 resumes after enable", riseCnt, 4);
    busRead(3'd3, d); chk("R10 completes after enable", 32'(d), 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    tRw8();
    tRw32();
    tLen1();
    tWo17();
    tBoth();
    tNoCs();
    tMask();
    tBusy();
    tStall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule